// File: doc/BRIEF.md
# Zero-Overhead Loop and Conditional-Skip Sequencer

This block sits beside the issue stage of a simple in-order core and steers instruction flow for hardware loops and predicated words. Each cycle the core presents whether a word is issuing, that word's PC, any decoded loop or skip request it carries, and two accumulator flags (zero and negative). The sequencer answers in the same cycle. It can tell the fetch unit to hold the PC so the current word issues again. It can tell it to reload the PC with a loop start address. It can clear the accumulator, mark the issuing word as suppressed so it does not write architectural state, or stall issue while a block loop is being set up.

Four request kinds exist. The first repeats the following word a counted number of times. The second does the same and also clears the accumulator. The third loops over an address range a counted number of times. The fourth tests up to three flag conditions and, if any of them fails, suppresses the next one or two issued words. Every count is written as the number of passes minus one, and the internal counters count down to zero. A single repeat may sit inside a block loop.

Top module: `loopseq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises, all outputs are low and no repeat, loop or pending skip remains; a skip still pending when reset is asserted does not suppress the next word after reset.
- R2: A request with `req_op`=1 and count K, on an issuing word, makes the next issued word issue K+1 times in total; `pc_hold` is high on the first K of those issues and low on the last. K=0 gives one issue with no hold.
- R3: `acc_clear` is high in the issue cycle of an accepted request with `req_op`=2, which otherwise behaves as R2. It is low for `req_op`=1.
- R4: While a single repeat is pending or running, any request on an issuing word is ignored: it causes no clear, and the running repeat keeps its count.
- R5: A request with `req_op`=3 and count K, start S and end E arms a loop. Each time the word at PC E issues while the loop counter is nonzero, `pc_reload` is high with `pc_target`=S and the counter decrements. When E issues with the counter at zero, the loop ends, and later issues of E do not reload.
- R6: An accepted `req_op`=3 request is followed by exactly three cycles with `stall` high, so it costs four cycles. A `req_op`=1 or 2 request adds no stall cycle.
- R7: When a single repeat runs on the end word of an active block loop, `pc_reload` stays low while `pc_hold` is high, and the reload happens on the final repetition.
- R8: A `req_op`=4 request whose test fails suppresses (`suppress` high) the next issued word, or the next two when `xc_two`=1. Cycles with `issue_valid` low are not counted and show `suppress` low.
- R9: A `req_op`=4 request whose test passes suppresses nothing. The flags are read only in the request's own cycle.
- R10: `xc_conds` holds three 3-bit slots, with slot i at bits [3i+2:3i]. The codes are 0 always, 1 zero, 2 nonzero, 3 negative, 4 negative or zero, 5 positive (neither), 6 not negative, 7 never. The test passes only if every slot is true.
- R11: A request carried by a suppressed word is ignored: it gives no clear, no repeat and no loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | A word issues this cycle |
| pc | input | AW | PC of the issuing word |
| req_op | input | 3 | Request: 0 none, 1 repeat, 2 repeat with clear, 3 block loop, 4 conditional skip |
| req_count | input | CW | Pass count minus one for requests 1 to 3 |
| req_start | input | AW | First address of the block loop |
| req_end | input | AW | Last address of the block loop |
| xc_two | input | 1 | Skip window is two words instead of one |
| xc_conds | input | 3*NCOND | Condition slots, encoding in R10 |
| flag_zero | input | 1 | Accumulator equals zero |
| flag_neg | input | 1 | Accumulator is negative |
| pc_hold | output | 1 | Do not advance the PC; reissue the same word |
| pc_reload | output | 1 | Load the PC from `pc_target` |
| pc_target | output | AW | Block loop start address |
| acc_clear | output | 1 | Zero the accumulator |
| suppress | output | 1 | The issuing word must not update state |
| stall | output | 1 | Block-loop setup cycle; no word may issue |

## Verification
The hardest case to reach is the end word of a block loop that is also the target of a single repeat. The loop reload has to wait behind several hold cycles and then fire on the final pass. The stimulus arms a block loop, lets its setup stall drain, and puts a repeat request on the word just before the end address. The skip window is tested across an idle cycle inside the window, and with a request hidden inside a suppressed word, so that a miscounted window or a leaked request shows up at the ports.

// File: rtl/loopseq_pkg.sv
package loopseq_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_RPT  = 3'd1,
        OP_RPTZ = 3'd2,
        OP_BLK  = 3'd3,
        OP_XC   = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        CC_ALWAYS = 3'd0,
        CC_ZERO   = 3'd1,
        CC_NZERO  = 3'd2,
        CC_NEG    = 3'd3,
        CC_NPOS   = 3'd4,
        CC_POS    = 3'd5,
        CC_NNEG   = 3'd6,
        CC_NEVER  = 3'd7
    } cc_e;

    localparam int CCW = 3;

    function automatic logic cc_true(input logic [2:0] cc, input logic z, input logic n);
        logic r;
        case (cc)
            CC_ALWAYS: r = 1'b1;
            CC_ZERO:   r = z;
            CC_NZERO:  r = !z;
            CC_NEG:    r = n;
            CC_NPOS:   r = n || z;
            CC_POS:    r = !n && !z;
            CC_NNEG:   r = !n;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/loopseq_rpt.sv
module loopseq_rpt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] count,
    input  logic          issue,
    output logic          hold,
    output logic          busy
);
    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } rpt_st_t;

    rpt_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        hold = 1'b0;
        if (issue && st_q.armed) begin
            if (st_q.cnt != '0) begin
                hold     = 1'b1;
                st_d.cnt = st_q.cnt - 1'b1;
            end else begin
                st_d.armed = 1'b0;
            end
        end
        if (start) begin
            st_d.armed = 1'b1;
            st_d.cnt   = count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.armed;

endmodule

// File: rtl/loopseq_blk.sv
module loopseq_blk #(
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int OVH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] addr_first,
    input  logic [AW-1:0] addr_last,
    input  logic          issue,
    input  logic [AW-1:0] pc,
    input  logic          hold_in,
    output logic          reload,
    output logic [AW-1:0] target,
    output logic          stall
);
    localparam int OW = $clog2(OVH + 1);
    localparam logic [OW-1:0] SETUP_EXTRA = OW'(OVH - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] brc;
        logic [AW-1:0] first;
        logic [AW-1:0] last;
        logic [OW-1:0] setup;
    } blk_st_t;

    blk_st_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        reload = 1'b0;
        if (st_q.setup != '0) st_d.setup = st_q.setup - 1'b1;
        if (issue && st_q.active && !hold_in && pc == st_q.last) begin
            if (st_q.brc != '0) begin
                reload   = 1'b1;
                st_d.brc = st_q.brc - 1'b1;
            end else begin
                st_d.active = 1'b0;
            end
        end
        if (start) begin
            st_d.active = 1'b1;
            st_d.brc    = count;
            st_d.first  = addr_first;
            st_d.last   = addr_last;
            st_d.setup  = SETUP_EXTRA;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign target = st_q.first;
    assign stall  = (st_q.setup != '0);

endmodule

// File: rtl/loopseq_xc.sv
module loopseq_xc
    import loopseq_pkg::*;
#(
    parameter int NCOND = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               two,
    input  logic [NCOND*CCW-1:0] conds,
    input  logic               flag_zero,
    input  logic               flag_neg,
    input  logic               issue,
    output logic               sup
);
    typedef struct packed {
        logic [1:0] skip;
    } xc_st_t;

    xc_st_t st_q, st_d;
    logic [NCOND-1:0] slot_ok;
    logic             all_ok;

    for (genvar g = 0; g < NCOND; g++) begin : g_slot
        assign slot_ok[g] = cc_true(conds[g*CCW +: CCW], flag_zero, flag_neg);
    end

    assign all_ok = &slot_ok;

    always_comb begin
        st_d = st_q;
        sup  = 1'b0;
        if (issue && st_q.skip != 2'd0) begin
            sup       = 1'b1;
            st_d.skip = st_q.skip - 2'd1;
        end
        if (start && !all_ok) st_d.skip = two ? 2'd2 : 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/loopseq_ctrl.sv
module loopseq_ctrl
    import loopseq_pkg::*;
#(
    parameter int AW      = 16,
    parameter int CW      = 16,
    parameter int NCOND   = 3,
    parameter int BLK_OVH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [AW-1:0]        pc,
    input  logic [2:0]           req_op,
    input  logic [CW-1:0]        req_count,
    input  logic [AW-1:0]        req_start,
    input  logic [AW-1:0]        req_end,
    input  logic                 xc_two,
    input  logic [NCOND*CCW-1:0] xc_conds,
    input  logic                 flag_zero,
    input  logic                 flag_neg,
    output logic                 pc_hold,
    output logic                 pc_reload,
    output logic [AW-1:0]        pc_target,
    output logic                 acc_clear,
    output logic                 suppress,
    output logic                 stall
);
    logic issue, accept, rpt_busy;
    logic rpt_go, blk_go, xc_go;

    assign issue  = issue_valid && !stall;
    assign accept = issue && !suppress && !rpt_busy;

    assign rpt_go    = accept && (req_op == OP_RPT || req_op == OP_RPTZ);
    assign acc_clear = accept && (req_op == OP_RPTZ);
    assign blk_go    = accept && (req_op == OP_BLK);
    assign xc_go     = accept && (req_op == OP_XC);

    loopseq_rpt #(.CW(CW)) rpt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rpt_go),
        .count (req_count),
        .issue (issue),
        .hold  (pc_hold),
        .busy  (rpt_busy)
    );

    loopseq_blk #(.AW(AW), .CW(CW), .OVH(BLK_OVH)) blk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (blk_go),
        .count      (req_count),
        .addr_first (req_start),
        .addr_last  (req_end),
        .issue      (issue),
        .pc         (pc),
        .hold_in    (pc_hold),
        .reload     (pc_reload),
        .target     (pc_target),
        .stall      (stall)
    );

    loopseq_xc #(.NCOND(NCOND)) xc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (xc_go),
        .two       (xc_two),
        .conds     (xc_conds),
        .flag_zero (flag_zero),
        .flag_neg  (flag_neg),
        .issue     (issue),
        .sup       (suppress)
    );

endmodule

// File: rtl/loopseq_ctrl_chk.sv
module loopseq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       issue_valid,
    input logic [2:0] req_op,
    input logic       pc_hold,
    input logic       pc_reload,
    input logic       acc_clear,
    input logic       suppress,
    input logic       stall
);
    // R7: a hold and a reload never coincide
    assert_hold_defers_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> !pc_reload);

    // R6: no flow action during a setup stall
    assert_stall_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!pc_hold && !pc_reload && !suppress && !acc_clear));

    // R6: a stall only starts after a block loop request
    assert_stall_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> ($past(req_op) == 3'd3 && $past(issue_valid)));

    // R3: clear only for a repeat-with-clear request on an issuing word
    assert_clear_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clear |-> (issue_valid && req_op == 3'd2));

    // R4: a running repeat blocks any clear
    assert_no_clear_while_rpt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> !acc_clear);

    // R8: suppression only on issuing words
    assert_sup_on_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        suppress |-> issue_valid);

    // R11: a suppressed word cannot clear
    assert_sup_no_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        suppress |-> !acc_clear);
endmodule

bind loopseq_ctrl loopseq_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .req_op      (req_op),
    .pc_hold     (pc_hold),
    .pc_reload   (pc_reload),
    .acc_clear   (acc_clear),
    .suppress    (suppress),
    .stall       (stall)
);

// File: tb/loopseq_ctrl_tb_top.sv
module loopseq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [15:0] pc = '0;
    logic [2:0]  req_op = '0;
    logic [15:0] req_count = '0;
    logic [15:0] req_start = '0;
    logic [15:0] req_end = '0;
    logic        xc_two = 1'b0;
    logic [8:0]  xc_conds = '0;
    logic        flag_zero = 1'b0;
    logic        flag_neg = 1'b0;
    logic        pc_hold, pc_reload, acc_clear, suppress, stall;
    logic [15:0] pc_target;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // expected {hold, reload, clear, suppress, stall}
    logic [4:0]  exp_q[$];
    logic [15:0] tgt_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    loopseq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .pc(pc),
        .req_op(req_op), .req_count(req_count), .req_start(req_start),
        .req_end(req_end), .xc_two(xc_two), .xc_conds(xc_conds),
        .flag_zero(flag_zero), .flag_neg(flag_neg), .pc_hold(pc_hold),
        .pc_reload(pc_reload), .pc_target(pc_target), .acc_clear(acc_clear),
        .suppress(suppress), .stall(stall)
    );

    task automatic drive(input logic iv, input logic [15:0] p, input logic [2:0] op,
                         input logic [15:0] cnt, input logic [15:0] st, input logic [15:0] en,
                         input logic two, input logic [8:0] cc, input logic fz, input logic fn,
                         input logic [4:0] e, input logic [15:0] et, input string tag);
        @(negedge clk);
        issue_valid = iv; pc = p; req_op = op; req_count = cnt;
        req_start = st; req_end = en; xc_two = two; xc_conds = cc;
        flag_zero = fz; flag_neg = fn;
        exp_q.push_back(e); tgt_q.push_back(et); tag_q.push_back(tag);
    endtask

    task automatic word(input logic [15:0] p, input logic [4:0] e, input logic [15:0] et,
                        input string tag);
        drive(1'b1, p, 3'd0, 16'd0, 16'd0, 16'd0, 1'b0, 9'd0, 1'b0, 1'b0, e, et, tag);
    endtask

    task automatic idle(input logic [4:0] e, input string tag);
        drive(1'b0, 16'd0, 3'd0, 16'd0, 16'd0, 16'd0, 1'b0, 9'd0, 1'b0, 1'b0, e, 16'd0, tag);
    endtask

    // monitor: compares after inputs settle, well away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (exp_q.size() != 0) begin
                logic [4:0]  e;
                logic [15:0] et;
                string       tg;
                logic [4:0]  got;
                e = exp_q.pop_front(); et = tgt_q.pop_front(); tg = tag_q.pop_front();
                got = {pc_hold, pc_reload, acc_clear, suppress, stall};
                vectors++;
                if (got !== e || (e[3] && pc_target !== et)) begin
                    errors++;
                    $display("FAIL %s: got flags %b target %h, expected flags %b target %h",
                             tg, got, pc_target, e, et);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        idle(5'b00000, "R1 reset");
        idle(5'b00000, "R1 reset");
        rst_n = 1'b1;
        idle(5'b00000, "R1 after reset");

        // R2 repeat count 2 -> three issues
        drive(1, 16'd10, 3'd1, 16'd2, 0, 0, 0, 0, 0, 0, 5'b00000, 0, "R2 request");
        word(16'd11, 5'b10000, 0, "R2 pass1");
        word(16'd11, 5'b10000, 0, "R2 pass2");
        word(16'd11, 5'b00000, 0, "R2 last");
        word(16'd12, 5'b00000, 0, "R2 after");

        // R3 repeat with clear, count 0 (boundary of R2)
        drive(1, 16'd20, 3'd2, 16'd0, 0, 0, 0, 0, 0, 0, 5'b00100, 0, "R3 clear");
        word(16'd21, 5'b00000, 0, "R3 single pass");
        word(16'd22, 5'b00000, 0, "R3 after");

        // R4 request ignored while repeat runs
        drive(1, 16'd30, 3'd1, 16'd1, 0, 0, 0, 0, 0, 0, 5'b00000, 0, "R4 request");
        drive(1, 16'd31, 3'd2, 16'd5, 0, 0, 0, 0, 0, 0, 5'b10000, 0, "R4 ignored no clear");
        word(16'd31, 5'b00000, 0, "R4 count kept");
        word(16'd32, 5'b00000, 0, "R4 no new repeat");

        // R5 / R6 block loop, two passes over 41..42
        drive(1, 16'd40, 3'd3, 16'd1, 16'd41, 16'd42, 0, 0, 0, 0, 5'b00000, 0, "R6 request");
        idle(5'b00001, "R6 stall1");
        idle(5'b00001, "R6 stall2");
        idle(5'b00001, "R6 stall3");
        idle(5'b00000, "R6 stall ends");
        word(16'd41, 5'b00000, 0, "R5 body");
        word(16'd42, 5'b01000, 16'd41, "R5 reload");
        word(16'd41, 5'b00000, 0, "R5 body2");
        word(16'd42, 5'b00000, 0, "R5 exit");
        word(16'd43, 5'b00000, 0, "R5 after");
        word(16'd42, 5'b00000, 0, "R5 inactive");

        // R7 single repeat on loop end word
        drive(1, 16'd50, 3'd3, 16'd1, 16'd51, 16'd52, 0, 0, 0, 0, 5'b00000, 0, "R7 loop req");
        idle(5'b00001, "R7 stall");
        idle(5'b00001, "R7 stall");
        idle(5'b00001, "R7 stall");
        drive(1, 16'd51, 3'd1, 16'd1, 0, 0, 0, 0, 0, 0, 5'b00000, 0, "R7 rpt req");
        word(16'd52, 5'b10000, 0, "R7 hold defers");
        word(16'd52, 5'b01000, 16'd51, "R7 reload last");
        word(16'd51, 5'b00000, 0, "R7 body");
        word(16'd52, 5'b00000, 0, "R7 exit");
        word(16'd53, 5'b00000, 0, "R7 after");

        // R9 pass, flags read only in test cycle
        drive(1, 16'd60, 3'd4, 0, 0, 0, 0, 9'o001, 1, 0, 5'b00000, 0, "R9 test");
        word(16'd61, 5'b00000, 0, "R9 no suppress");
        word(16'd62, 5'b00000, 0, "R9 after");

        // R8 fail, two-word window across an idle cycle
        drive(1, 16'd70, 3'd4, 0, 0, 0, 1, 9'o005, 0, 1, 5'b00000, 0, "R8 test");
        word(16'd71, 5'b00010, 0, "R8 sup1");
        idle(5'b00000, "R8 idle");
        word(16'd72, 5'b00010, 0, "R8 sup2");
        word(16'd73, 5'b00000, 0, "R8 window over");

        // R10 three slots
        drive(1, 16'd80, 3'd4, 0, 0, 0, 0, {3'd4, 3'd2, 3'd3}, 0, 1, 5'b00000, 0, "R10 all true");
        word(16'd81, 5'b00000, 0, "R10 pass");
        drive(1, 16'd90, 3'd4, 0, 0, 0, 0, {3'd2, 3'd4, 3'd6}, 1, 0, 5'b00000, 0, "R10 one false");
        word(16'd91, 5'b00010, 0, "R10 fail");
        drive(1, 16'd95, 3'd4, 0, 0, 0, 0, 9'o700, 1, 0, 5'b00000, 0, "R10 never");
        word(16'd96, 5'b00010, 0, "R10 never fails");
        drive(1, 16'd100, 3'd4, 0, 0, 0, 0, 9'o000, 0, 0, 5'b00000, 0, "R10 always");
        word(16'd101, 5'b00000, 0, "R10 always passes");

        // R11 request in a suppressed word
        drive(1, 16'd110, 3'd4, 0, 0, 0, 0, 9'o003, 0, 0, 5'b00000, 0, "R11 test");
        drive(1, 16'd111, 3'd2, 16'd3, 0, 0, 0, 0, 0, 0, 5'b00010, 0, "R11 no clear");
        word(16'd112, 5'b00000, 0, "R11 no repeat");

        // R1 reset clears a pending skip
        drive(1, 16'd120, 3'd4, 0, 0, 0, 1, 9'o001, 0, 0, 5'b00000, 0, "R1 pre");
        rst_n = 1'b0;
        idle(5'b00000, "R1 in reset");
        rst_n = 1'b1;
        word(16'd121, 5'b00000, 0, "R1 skip cleared");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule